// File: doc/BRIEF.md
# Linear Frequency-Sweep Phase Generator

This block is the numeric front end of a direct digital synthesizer that can sweep its own output frequency in a straight line. A 48-bit tuning word drives a 48-bit phase accumulator that advances once per system clock. The top 16 bits of that accumulator leave the block through a register and feed a phase-to-amplitude stage that sits outside this block. In sweep mode a second accumulator moves the tuning word by a signed step once per programmable interval. A hold input can freeze the sweep, a zero step stops it, and a clear control forces the phase to zero so that the output ends at once.

Software writes go into shadow copies. They take effect together on an update strobe. The strobe comes either from an input pin or from an internal 32-bit counter that fires at a fixed period, so register changes can be lined up with sweep timing to the exact clock. No end frequency is programmed. The sweep runs until stopped, and the tuning word is held between 0 and 2^47 (half the clock rate).

Top module: `chirp_dds_core`

## Requirements
- R1: A write (wr_en_i high at a clock edge) goes only to a shadow register, selected by wr_sel_i: 0 start tuning word, 1 signed step, 2 interval reload (20 bits), 3 control, 4 auto-update period (32 bits). Outputs do not change until a later update strobe.
- R2: Control bit 0 clear selects single-tone mode. The tuning word then stays constant at the committed start word, whatever step is programmed.
- R3: Control bit 0 set selects sweep mode. An update that commits interval value N reloads the interval counter. The tuning word then moves by the step every N+1 clocks, first N+1 clocks after that update.
- R4: While hold_i is high, the tuning word and the interval counter do not change. After release the sweep continues from the frozen word and the frozen count.
- R5: A committed step of zero leaves the tuning word constant in sweep mode.
- R6: Each step is clamped so the tuning word stays in 0 to 2^47 inclusive. A committed start word is limited to 2^47 as well.
- R7: While control bit 1 is committed, the phase accumulator is forced to zero, so phase_o reads zero two clocks later. After release the phase restarts from zero.
- R8: The phase accumulator adds the tuning word every clock. phase_o is its top 16 bits, registered one clock later.
- R9: With control bit 2 committed, an internal counter issues an update every P+1 clocks (P = committed period). The first one comes P+1 clocks after the enabling update. A start word is reloaded only on an update that follows a write of it.
- R10: Synchronous reset clears the tuning word, the phase and all registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_i | input | 1 | Freezes the sweep while high |
| wr_en_i | input | 1 | Shadow register write enable |
| wr_sel_i | input | 3 | Shadow register select |
| wr_data_i | input | 48 | Write data, right-aligned |
| ext_update_i | input | 1 | External update strobe |
| phase_o | output | 16 | Registered top bits of the phase accumulator |
| freq_o | output | 48 | Current tuning word |

## Verification
The hardest case to reach from the ports is the timing of the automatic update. Its counter is hidden, so the bench turns it on with one external update that puts the counter in a known state. It then writes new start words partway through the period and checks that each one appears exactly P+1 clocks after the previous commit, not earlier. Hold release is checked at the cycle level too. The bench freezes the sweep just after a step, so the count left over at release fixes when the next step arrives.

// File: rtl/chirp_dds_pkg.sv
package chirp_dds_pkg;

  typedef enum logic [2:0] {
    SEL_START = 3'd0,
    SEL_DELTA = 3'd1,
    SEL_RATE  = 3'd2,
    SEL_CTRL  = 3'd3,
    SEL_AUTO  = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic auto_en;
    logic clr;
    logic sweep;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/chirp_auto_tick.sv
module chirp_auto_tick #(
  parameter int unsigned AUTO_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [AUTO_W-1:0] period,
  output logic              tick
);

  logic [AUTO_W-1:0] cnt_q;

  assign tick = enable && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!enable || tick) begin
      cnt_q <= period;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/chirp_regs.sv
module chirp_regs
  import chirp_dds_pkg::*;
#(
  parameter int unsigned FREQ_W = 48,
  parameter int unsigned RATE_W = 20,
  parameter int unsigned AUTO_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [FREQ_W-1:0] wr_data,
  input  logic              ext_update,
  output logic              commit,
  output logic              start_commit,
  output logic [FREQ_W-1:0] sh_start,
  output logic [RATE_W-1:0] sh_rate,
  output logic [FREQ_W-1:0] delta_act,
  output logic [RATE_W-1:0] rate_act,
  output ctrl_t             ctrl_act
);

  logic [FREQ_W-1:0] sh_delta;
  ctrl_t             sh_ctrl;
  logic [AUTO_W-1:0] sh_period;
  logic              start_dirty;
  logic              auto_tick;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(wr_sel);

  chirp_auto_tick #(.AUTO_W(AUTO_W)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .enable (ctrl_act.auto_en),
    .period (sh_period),
    .tick   (auto_tick)
  );

  assign commit       = ext_update || auto_tick;
  assign start_commit = commit && start_dirty;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_start  <= '0;
      sh_delta  <= '0;
      sh_rate   <= '0;
      sh_ctrl   <= '0;
      sh_period <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_START: sh_start  <= wr_data;
        SEL_DELTA: sh_delta  <= wr_data;
        SEL_RATE:  sh_rate   <= wr_data[RATE_W-1:0];
        SEL_CTRL:  sh_ctrl   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        SEL_AUTO:  sh_period <= wr_data[AUTO_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_dirty <= 1'b0;
    end else if (wr_en && sel == SEL_START) begin
      start_dirty <= 1'b1;
    end else if (commit) begin
      start_dirty <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      delta_act <= '0;
      rate_act  <= '0;
      ctrl_act  <= '0;
    end else if (commit) begin
      delta_act <= sh_delta;
      rate_act  <= sh_rate;
      ctrl_act  <= sh_ctrl;
    end
  end

endmodule

// File: rtl/chirp_ramp.sv
module chirp_ramp #(
  parameter int unsigned FREQ_W = 48,
  parameter int unsigned RATE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              commit,
  input  logic              start_commit,
  input  logic [FREQ_W-1:0] start_val,
  input  logic [RATE_W-1:0] reload_rate,
  input  logic              sweep,
  input  logic [FREQ_W-1:0] delta,
  input  logic [RATE_W-1:0] rate,
  output logic [FREQ_W-1:0] freq
);

  localparam int unsigned SUM_W = FREQ_W + 2;
  localparam logic [SUM_W-1:0] CEIL_X = SUM_W'(1) << (FREQ_W - 1);
  localparam logic [FREQ_W-1:0] CEIL  = FREQ_W'(1) << (FREQ_W - 1);

  logic [RATE_W-1:0] cnt_q;
  logic [SUM_W-1:0]  sum;
  logic [FREQ_W-1:0] stepped;
  logic [FREQ_W-1:0] start_lim;

  assign sum = {2'b00, freq} + {{2{delta[FREQ_W-1]}}, delta};

  always_comb begin
    if (sum[SUM_W-1]) begin
      stepped = '0;
    end else if (sum > CEIL_X) begin
      stepped = CEIL;
    end else begin
      stepped = sum[FREQ_W-1:0];
    end
  end

  assign start_lim = (start_val > CEIL) ? CEIL : start_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      freq  <= '0;
      cnt_q <= '0;
    end else if (commit) begin
      cnt_q <= reload_rate;
      if (start_commit) begin
        freq <= start_lim;
      end
    end else if (sweep && !hold) begin
      if (cnt_q == '0) begin
        freq  <= stepped;
        cnt_q <= rate;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/chirp_phase.sv
module chirp_phase #(
  parameter int unsigned FREQ_W = 48,
  parameter int unsigned OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [FREQ_W-1:0] freq,
  output logic [OUT_W-1:0]  phase_out
);

  logic [FREQ_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_q + freq;
    end
  end

  generate
    if (OUT_W >= FREQ_W) begin : g_full
      always_ff @(posedge clk) begin
        if (rst) phase_out <= '0;
        else     phase_out <= OUT_W'(acc_q);
      end
    end else begin : g_trunc
      always_ff @(posedge clk) begin
        if (rst) phase_out <= '0;
        else     phase_out <= acc_q[FREQ_W-1 -: OUT_W];
      end
    end
  endgenerate

endmodule

// File: rtl/chirp_dds_core.sv
module chirp_dds_core
  import chirp_dds_pkg::*;
#(
  parameter int unsigned FREQ_W  = 48,
  parameter int unsigned RATE_W  = 20,
  parameter int unsigned AUTO_W  = 32,
  parameter int unsigned PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [FREQ_W-1:0]  wr_data_i,
  input  logic               ext_update_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [FREQ_W-1:0]  freq_o
);

  logic              commit;
  logic              start_commit;
  logic [FREQ_W-1:0] sh_start;
  logic [RATE_W-1:0] sh_rate;
  logic [FREQ_W-1:0] delta_act;
  logic [RATE_W-1:0] rate_act;
  ctrl_t             ctrl_act;
  logic              clr_act;
  logic              sweep_act;

  assign clr_act   = ctrl_act.clr;
  assign sweep_act = ctrl_act.sweep;

  chirp_regs #(.FREQ_W(FREQ_W), .RATE_W(RATE_W), .AUTO_W(AUTO_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en_i),
    .wr_sel       (wr_sel_i),
    .wr_data      (wr_data_i),
    .ext_update   (ext_update_i),
    .commit       (commit),
    .start_commit (start_commit),
    .sh_start     (sh_start),
    .sh_rate      (sh_rate),
    .delta_act    (delta_act),
    .rate_act     (rate_act),
    .ctrl_act     (ctrl_act)
  );

  chirp_ramp #(.FREQ_W(FREQ_W), .RATE_W(RATE_W)) u_ramp (
    .clk          (clk),
    .rst          (rst),
    .hold         (hold_i),
    .commit       (commit),
    .start_commit (start_commit),
    .start_val    (sh_start),
    .reload_rate  (sh_rate),
    .sweep        (sweep_act),
    .delta        (delta_act),
    .rate         (rate_act),
    .freq         (freq_o)
  );

  chirp_phase #(.FREQ_W(FREQ_W), .OUT_W(PHASE_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_act),
    .freq      (freq_o),
    .phase_out (phase_o)
  );

endmodule

// File: rtl/chirp_dds_checker.sv
module chirp_dds_checker #(
  parameter int unsigned FREQ_W  = 48,
  parameter int unsigned PHASE_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               hold_i,
  input logic               commit,
  input logic               clr_act,
  input logic               sweep_act,
  input logic [FREQ_W-1:0]  delta_act,
  input logic [FREQ_W-1:0]  freq_o,
  input logic [PHASE_W-1:0] phase_o
);

  localparam logic [FREQ_W-1:0] CEIL = FREQ_W'(1) << (FREQ_W - 1);

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (freq_o == '0 && phase_o == '0));

  a_r4_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !commit) |=> $stable(freq_o));

  a_r2_single_tone_flat: assert property (@(posedge clk) disable iff (rst)
    (!sweep_act && !commit) |=> $stable(freq_o));

  a_r5_zero_step_flat: assert property (@(posedge clk) disable iff (rst)
    (delta_act == '0 && !commit) |=> $stable(freq_o));

  a_r6_within_nyquist: assert property (@(posedge clk) disable iff (rst)
    freq_o <= CEIL);

  a_r7_clear_zeroes_phase: assert property (@(posedge clk) disable iff (rst)
    clr_act |-> ##2 (phase_o == '0));

endmodule

bind chirp_dds_core chirp_dds_checker #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hold_i    (hold_i),
  .commit    (commit),
  .clr_act   (clr_act),
  .sweep_act (sweep_act),
  .delta_act (delta_act),
  .freq_o    (freq_o),
  .phase_o   (phase_o)
);

// File: tb/chirp_dds_core_bench.sv
module chirp_dds_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] CEIL = 48'd1 << 47;
  localparam logic [47:0] TONE = 48'd5 << 32;

  typedef struct {
    bit          is_phase;
    logic [47:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hold_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [47:0] wr_data_i = '0;
  logic        ext_update_i = 1'b0;
  logic [15:0] phase_o;
  logic [47:0] freq_o;

  item_t q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chirp_dds_core u_chirp_dds_core (
    .clk          (clk),
    .rst          (rst),
    .hold_i       (hold_i),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .ext_update_i (ext_update_i),
    .phase_o      (phase_o),
    .freq_o       (freq_o)
  );

  // monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        item_t it;
        logic [47:0] act;
        it  = q.pop_front();
        act = it.is_phase ? {32'd0, phase_o} : freq_o;
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s actual=%0d expected=%0d", it.req,
                   it.is_phase ? "phase" : "freq", act, it.exp);
        end
      end
    end
  end

  task automatic chk_step(input bit is_ph, input logic [47:0] e, input string r);
    item_t it;
    it.is_phase = is_ph;
    it.exp      = e;
    it.req      = r;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [47:0] d);
    wr_en_i   = 1'b1;
    wr_sel_i  = sel;
    wr_data_i = d;
    @(negedge clk);
    wr_en_i   = 1'b0;
  endtask

  task automatic upd_chk(input bit is_ph, input logic [47:0] e, input string r);
    ext_update_i = 1'b1;
    chk_step(is_ph, e, r);
    ext_update_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R10 reset state
    chk_step(1'b0, 48'd0, "R10");
    chk_step(1'b1, 48'd0, "R10");

    // R8 phase integration in single tone
    wr(3'd0, TONE);
    wr(3'd3, 48'd0);
    upd_chk(1'b0, TONE, "R8");
    for (int k = 1; k <= 7; k++) chk_step(1'b1, 48'(5 * (k - 1)), "R8");

    // R7 clear forces phase to zero, then restart from zero
    wr(3'd3, 48'd2);
    upd_chk(1'b0, TONE, "R7");
    chk_step(1'b0, TONE, "R7");
    for (int k = 2; k <= 5; k++) chk_step(1'b1, 48'd0, "R7");
    wr(3'd3, 48'd0);
    upd_chk(1'b1, 48'd0, "R7");
    for (int k = 1; k <= 5; k++) chk_step(1'b1, 48'(5 * (k - 1)), "R7");

    // R1 shadow write without update has no effect
    wr(3'd0, 48'd777);
    for (int k = 0; k < 3; k++) chk_step(1'b0, TONE, "R1");
    upd_chk(1'b0, 48'd777, "R1");

    // R3 sweep: step 7 every 4 clocks
    wr(3'd0, 48'd1000);
    wr(3'd1, 48'd7);
    wr(3'd2, 48'd3);
    wr(3'd3, 48'd1);
    upd_chk(1'b0, 48'd1000, "R3");
    for (int k = 1; k <= 12; k++) chk_step(1'b0, 48'(1000 + 7 * (k / 4)), "R3");

    // R4 hold freezes, then resumes with the frozen count
    hold_i = 1'b1;
    for (int k = 0; k < 10; k++) chk_step(1'b0, 48'd1021, "R4");
    hold_i = 1'b0;
    for (int j = 1; j <= 8; j++) chk_step(1'b0, 48'(1021 + 7 * (j / 4)), "R4");

    // R5 zero step keeps the word constant in sweep mode
    wr(3'd0, 48'd5000);
    wr(3'd1, 48'd0);
    wr(3'd2, 48'd0);
    upd_chk(1'b0, 48'd5000, "R5");
    for (int k = 1; k <= 7; k++) chk_step(1'b0, 48'd5000, "R5");

    // R6 clamp at the top
    wr(3'd0, CEIL - 48'd10);
    wr(3'd1, 48'd100);
    upd_chk(1'b0, CEIL - 48'd10, "R6");
    for (int k = 1; k <= 4; k++) chk_step(1'b0, CEIL, "R6");

    // R6 clamp at zero with a negative step
    wr(3'd0, 48'd250);
    wr(3'd1, -48'sd100);
    upd_chk(1'b0, 48'd250, "R6");
    chk_step(1'b0, 48'd150, "R6");
    chk_step(1'b0, 48'd50, "R6");
    chk_step(1'b0, 48'd0, "R6");
    chk_step(1'b0, 48'd0, "R6");

    // R2 single tone ignores a nonzero step
    wr(3'd0, 48'd3000);
    wr(3'd1, 48'd9);
    wr(3'd3, 48'd0);
    upd_chk(1'b0, 48'd3000, "R2");
    for (int k = 1; k <= 5; k++) chk_step(1'b0, 48'd3000, "R2");

    // R9 automatic update every P+1 = 6 clocks
    wr(3'd4, 48'd5);
    wr(3'd3, 48'd4);
    wr(3'd0, 48'd4000);
    upd_chk(1'b0, 48'd4000, "R9");
    wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 48'd4444;
    chk_step(1'b0, 48'd4000, "R9");
    wr_en_i = 1'b0;
    for (int k = 2; k <= 5; k++) chk_step(1'b0, 48'd4000, "R9");
    chk_step(1'b0, 48'd4444, "R9");
    wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 48'd4555;
    chk_step(1'b0, 48'd4444, "R9");
    wr_en_i = 1'b0;
    for (int k = 8; k <= 11; k++) chk_step(1'b0, 48'd4444, "R9");
    chk_step(1'b0, 48'd4555, "R9");
    for (int k = 13; k <= 15; k++) chk_step(1'b0, 48'd4555, "R9");

    idle(3);
    done = 1'b1;
    finish_run();
  end

endmodule